// File: doc/BRIEF.md
# Extended Burst-Mode Handshake Controller

This block is a clocked four-state controller that watches three single-bit control inputs (`a`, `b`, `c`) and drives two registered outputs (`x`, `y`). A state is left only when every edge of one of its input bursts has been seen. The order of edges inside a burst does not matter. The output burst and the state change are then written together in one clock cycle. The environment is expected to run in fundamental mode. After any state change it must hold its inputs still for a fixed settle window. An input edge that arrives inside that window is rejected and flagged.

The states are idle, armed, held and drain. Idle moves to armed on `a` rising, and `y` rises. While the block is idle, input `b` is a directed don't-care: it may rise, fall or glitch at any time, and it neither completes nor blocks the burst. Armed moves to held on `c` rising, and `y` falls. Held moves back to armed on `c` falling, and `y` rises again. Armed moves to drain on `a` falling, which raises `x` and drops `y`. Drain returns to idle on `b` falling, and `x` falls. Parameter `B_DDC` = 0 selects a strict variant. In that variant, leaving idle needs both `a` rising and `b` rising, in either order. Any input edge that is illegal for the current state sets a sticky error output.

Inputs are assumed to be synchronous to `clk` already. A sample register and a previous-value register turn level changes into edges. Edges collect in per-state accumulators, which are cleared whenever the state changes.

Top module: `ebm_ctrl`

## Requirements
- R1: While and after a synchronous active-high reset, the block is idle with `x`=0, `y`=0 and `err`=0.
- R2: In idle, a rising edge on `a` completes the burst. The block becomes armed with `x`=0, `y`=1. A rising edge on `b` in the same cycle is accepted.
- R3: With `B_DDC`=1 and the block idle, edges on `b` in either direction leave `x`, `y` and `err` unchanged and do not stop a later `a` rising edge from completing the burst.
- R4: In armed, a rising edge on `c` gives held (`x`=0, `y`=0). In held, a falling edge on `c` returns to armed (`y`=1).
- R5: In armed, a falling edge on `a` gives drain (`x`=1, `y`=0). In drain, a falling edge on `b` gives idle (`x`=0, `y`=0).
- R6: An input change set up before clock edge E0 is sampled at E0. It changes `x`/`y` at edge E1, one cycle later, and not earlier.
- R7: An input edge that belongs to no arc of the current state sets `err`. The state does not move on that edge.
- R8: An input edge evaluated in any of the `SETTLE_CYC` cycles after a state change is ignored and sets `err`. With the default `SETTLE_CYC`=2, a change sampled one edge after the state change is rejected, and one sampled two edges after it is accepted.
- R9: If `c` rises and `a` falls in the same cycle while armed, the `c` arc wins (held) and `err` is set.
- R10: Once `err` is set, it stays set until reset, while the state machine keeps running.
- R11: With `B_DDC`=0, idle needs both `a` rising and `b` rising, in either order across cycles, before the block becomes armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | 1 | Control input a (synchronous to clk) |
| b | input | 1 | Control input b; directed don't-care while idle when B_DDC=1 |
| c | input | 1 | Control input c |
| x | output | 1 | Registered output x, high in drain |
| y | output | 1 | Registered output y, high in armed |
| err | output | 1 | Sticky error: illegal edge, settle-window edge or ambiguous burst |

## Verification
The hardest conditions to reach from the ports are the fundamental-mode violation and its exact boundary. Both depend on where an input change falls relative to the clock edge that wrote the state. The stimulus therefore drives `c` on the first falling clock edge after `y` is seen to rise, which puts it inside the window. A second case drives `c` exactly one cycle later, just past the window. A legal walk through all four states driven from `$urandom` also toggles `b` while the block is idle, to cover the don't-care arc. Separate directed cases cover the ambiguous simultaneous burst and the strict variant, with both edge orders.

// File: rtl/ebm_pkg.sv
package ebm_pkg;

  localparam int NUM_IN = 3;
  localparam int IN_A   = 0;
  localparam int IN_B   = 1;
  localparam int IN_C   = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_HELD  = 2'd2,
    ST_DRAIN = 2'd3
  } ebm_state_t;

  localparam logic [NUM_IN-1:0] BIT_A = NUM_IN'(1) << IN_A;
  localparam logic [NUM_IN-1:0] BIT_B = NUM_IN'(1) << IN_B;
  localparam logic [NUM_IN-1:0] BIT_C = NUM_IN'(1) << IN_C;

endpackage

// File: rtl/ebm_edge_sampler.sv
module ebm_edge_sampler #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] in_lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] smp_q;
  logic [WIDTH-1:0] prv_q;

  // sample register then previous-value register; edges compare the two
  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= '0;
      prv_q <= '0;
    end else begin
      smp_q <= in_lvl;
      prv_q <= smp_q;
    end
  end

  assign rise = smp_q & ~prv_q;
  assign fall = ~smp_q & prv_q;

endmodule

// File: rtl/ebm_settle_timer.sv
module ebm_settle_timer #(
  parameter int SETTLE_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  localparam int CW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(SETTLE_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/ebm_burst_tracker.sv
module ebm_burst_tracker
  import ebm_pkg::*;
#(
  parameter bit B_DDC = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  ebm_state_t        state,
  input  logic [NUM_IN-1:0] rise,
  input  logic [NUM_IN-1:0] fall,
  input  logic              accept,
  input  logic              clear,
  output logic [NUM_IN-1:0] seen_rise,
  output logic [NUM_IN-1:0] seen_fall,
  output logic              stray
);

  logic [NUM_IN-1:0] idle_r, idle_f;
  logic [NUM_IN-1:0] allow_r, allow_f;
  logic [NUM_IN-1:0] take_r, take_f;
  logic [NUM_IN-1:0] acc_r, acc_f;

  // idle arc: b is either a free don't-care or a compulsory rising edge
  generate
    if (B_DDC) begin : g_ddc
      assign idle_r = BIT_A | BIT_B;
      assign idle_f = BIT_B;
    end else begin : g_strict
      assign idle_r = BIT_A | BIT_B;
      assign idle_f = '0;
    end
  endgenerate

  always_comb begin
    allow_r = '0;
    allow_f = '0;
    case (state)
      ST_IDLE:  begin allow_r = idle_r; allow_f = idle_f; end
      ST_ARMED: begin allow_r = BIT_C;  allow_f = BIT_A;  end
      ST_HELD:  begin allow_r = '0;     allow_f = BIT_C;  end
      ST_DRAIN: begin allow_r = '0;     allow_f = BIT_B;  end
      default:  begin allow_r = '0;     allow_f = '0;     end
    endcase
  end

  assign take_r    = accept ? (rise & allow_r) : '0;
  assign take_f    = accept ? (fall & allow_f) : '0;
  assign seen_rise = acc_r | take_r;
  assign seen_fall = acc_f | take_f;
  assign stray     = accept && ((|(rise & ~allow_r)) || (|(fall & ~allow_f)));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_r <= '0;
      acc_f <= '0;
    end else begin
      acc_r <= seen_rise;
      acc_f <= seen_fall;
    end
  end

endmodule

// File: rtl/ebm_ctrl.sv
module ebm_ctrl
  import ebm_pkg::*;
#(
  parameter int SETTLE_CYC = 2,
  parameter bit B_DDC      = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic a,
  input  logic b,
  input  logic c,
  output logic x,
  output logic y,
  output logic err
);

  logic [NUM_IN-1:0] in_vec;
  logic [NUM_IN-1:0] rise, fall;
  logic [NUM_IN-1:0] seen_rise, seen_fall;
  logic              stray;
  logic              settle_busy;
  logic              edge_any;
  logic              late_edge;
  logic              conflict;
  logic              advance;
  ebm_state_t        state_q, state_d;

  always_comb begin
    in_vec       = '0;
    in_vec[IN_A] = a;
    in_vec[IN_B] = b;
    in_vec[IN_C] = c;
  end

  ebm_edge_sampler #(.WIDTH(NUM_IN)) i_sampler (
    .clk    (clk),
    .rst    (rst),
    .in_lvl (in_vec),
    .rise   (rise),
    .fall   (fall)
  );

  ebm_burst_tracker #(.B_DDC(B_DDC)) i_tracker (
    .clk       (clk),
    .rst       (rst),
    .state     (state_q),
    .rise      (rise),
    .fall      (fall),
    .accept    (!settle_busy),
    .clear     (advance),
    .seen_rise (seen_rise),
    .seen_fall (seen_fall),
    .stray     (stray)
  );

  ebm_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) i_settle (
    .clk   (clk),
    .rst   (rst),
    .start (advance),
    .busy  (settle_busy)
  );

  assign edge_any  = (|rise) || (|fall);
  assign late_edge = settle_busy && edge_any;

  always_comb begin
    state_d  = state_q;
    conflict = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (seen_rise[IN_A] && (B_DDC || seen_rise[IN_B])) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (seen_rise[IN_C]) begin
          state_d  = ST_HELD;
          conflict = seen_fall[IN_A];
        end else if (seen_fall[IN_A]) begin
          state_d = ST_DRAIN;
        end
      end
      ST_HELD: begin
        if (seen_fall[IN_C]) state_d = ST_ARMED;
      end
      ST_DRAIN: begin
        if (seen_fall[IN_B]) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign advance = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      x       <= 1'b0;
      y       <= 1'b0;
      err     <= 1'b0;
    end else begin
      state_q <= state_d;
      x       <= (state_d == ST_DRAIN);
      y       <= (state_d == ST_ARMED);
      err     <= err | stray | late_edge | conflict;
    end
  end

endmodule

// File: rtl/ebm_ctrl_chk.sv
module ebm_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic x,
  input logic y,
  input logic err,
  input logic busy,
  input logic edge_any
);

  logic rst_q;

  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_CLEARS: assert (!x && !y && !err); // R1
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R10

  AST_QUIET_IN_SETTLE: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable({x, y})); // R8

  AST_LATE_EDGE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (busy && edge_any) |=> err); // R8

  AST_OUT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    !$stable({x, y}) |-> $past(edge_any)); // R6

  AST_DRAIN_FROM_ARMED: assert property (@(posedge clk) disable iff (rst)
    $rose(x) |-> $past(y)); // R5

endmodule

bind ebm_ctrl ebm_ctrl_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .x        (x),
  .y        (y),
  .err      (err),
  .busy     (settle_busy),
  .edge_any (edge_any)
);

// File: tb/test_ebm_ctrl.sv
`timescale 1ns/1ps
module test_ebm_ctrl;

  localparam int SETTLE = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic da = 1'b0, db = 1'b0, dc = 1'b0;
  logic sa = 1'b0, sb = 1'b0, sc = 1'b0;
  logic x, y, err;
  logic xs, ys, errs;

  int vectors = 0;
  int fails   = 0;

  logic [1:0] mst  = 2'd0;
  logic       merr = 1'b0;
  logic [2:0] lvl  = 3'b000;

  always #5 clk = ~clk;

  ebm_ctrl #(.SETTLE_CYC(SETTLE), .B_DDC(1'b1)) i_ebm_ctrl (
    .clk(clk), .rst(rst), .a(da), .b(db), .c(dc), .x(x), .y(y), .err(err)
  );

  ebm_ctrl #(.SETTLE_CYC(SETTLE), .B_DDC(1'b0)) i_strict (
    .clk(clk), .rst(rst), .a(sa), .b(sb), .c(sc), .x(xs), .y(ys), .err(errs)
  );

  // reference: {bad, next_state} for one isolated input change (bit0=a, bit1=b, bit2=c)
  function automatic logic [2:0] model_step(input logic [1:0] st, input logic [2:0] o,
                                            input logic [2:0] n);
    logic [2:0] r, f, ar, af;
    logic [1:0] nx;
    logic bad;
    r = n & ~o; f = o & ~n; nx = st; bad = 1'b0;
    case (st)
      2'd0: begin ar = 3'b011; af = 3'b010; if (r[0]) nx = 2'd1; end
      2'd1: begin
        ar = 3'b100; af = 3'b001;
        if (r[2]) begin nx = 2'd2; bad = f[0]; end
        else if (f[0]) nx = 2'd3;
      end
      2'd2: begin ar = 3'b000; af = 3'b100; if (f[2]) nx = 2'd1; end
      default: begin ar = 3'b000; af = 3'b010; if (f[1]) nx = 2'd0; end
    endcase
    bad = bad | (|(r & ~ar)) | (|(f & ~af));
    return {bad, nx};
  endfunction

  function automatic logic exp_x(input logic [1:0] st); return st == 2'd3; endfunction
  function automatic logic exp_y(input logic [1:0] st); return st == 2'd1; endfunction

  task automatic chk1(input string req, input string nm, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: %s = %0b, expected %0b", req, nm, act, exp);
    end
  endtask

  task automatic check_out(input string req);
    chk1(req, "x", x, exp_x(mst));
    chk1(req, "y", y, exp_y(mst));
    chk1(req, "err", err, merr);
  endtask

  task automatic apply(input logic [2:0] v, input string req);
    logic [2:0] m;
    m = model_step(mst, lvl, v);
    @(negedge clk);
    {dc, db, da} = v;
    lvl  = v;
    mst  = m[1:0];
    merr = merr | m[2];
    repeat (SETTLE + 2) @(negedge clk);
    check_out(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    {dc, db, da} = 3'b000;
    {sc, sb, sa} = 3'b000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mst = 2'd0; merr = 1'b0; lvl = 3'b000;
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  initial begin
    int seed;
    seed = $urandom(32'd7321);

    // R1: reset state
    do_reset();
    check_out("R1");

    // R6: latency of exactly one cycle after sampling
    @(negedge clk);
    {dc, db, da} = 3'b011;
    @(negedge clk);
    chk1("R6", "y early", y, 1'b0);
    @(negedge clk);
    chk1("R6", "y", y, 1'b1);
    lvl = 3'b011; mst = 2'd1;
    repeat (SETTLE + 1) @(negedge clk);
    check_out("R2");

    // R3: b toggles while idle, then a completes
    do_reset();
    apply(3'b010, "R3");
    apply(3'b000, "R3");
    apply(3'b010, "R3");
    apply(3'b011, "R2");
    // R4 and R5: full walk
    apply(3'b111, "R4");
    apply(3'b011, "R4");
    apply(3'b010, "R5");
    apply(3'b000, "R5");

    // R7: illegal edge in idle, then R10 sticky across legal moves
    do_reset();
    apply(3'b100, "R7");
    apply(3'b101, "R10");
    apply(3'b100, "R10");

    // R8: edge inside settle window is rejected
    do_reset();
    @(negedge clk);
    {dc, db, da} = 3'b011;
    repeat (2) @(negedge clk);
    chk1("R8", "y", y, 1'b1);
    dc = 1'b1;
    repeat (SETTLE + 3) @(negedge clk);
    lvl = 3'b111; mst = 2'd1; merr = 1'b1;
    check_out("R8");
    apply(3'b110, "R8");

    // R8 boundary: first accepted moment
    do_reset();
    @(negedge clk);
    {dc, db, da} = 3'b011;
    repeat (2) @(negedge clk);
    chk1("R8", "y", y, 1'b1);
    @(negedge clk);
    dc = 1'b1;
    repeat (SETTLE + 3) @(negedge clk);
    lvl = 3'b111; mst = 2'd2;
    check_out("R8");

    // R9: simultaneous c rise and a fall while armed
    do_reset();
    apply(3'b011, "R9");
    apply(3'b110, "R9");

    // R11: strict variant, both orders
    do_reset();
    @(negedge clk); sb = 1'b1;
    repeat (SETTLE + 2) @(negedge clk);
    chk1("R11", "ys", ys, 1'b0);
    sa = 1'b1;
    repeat (SETTLE + 2) @(negedge clk);
    chk1("R11", "ys", ys, 1'b1);
    do_reset();
    @(negedge clk); sa = 1'b1;
    repeat (SETTLE + 2) @(negedge clk);
    chk1("R11", "ys", ys, 1'b0);
    sb = 1'b1;
    repeat (SETTLE + 2) @(negedge clk);
    chk1("R11", "ys", ys, 1'b1);
    chk1("R11", "errs", errs, 1'b0);

    // random legal walk (R2 R3 R4 R5)
    do_reset();
    for (int i = 0; i < 200; i++) begin
      case (mst)
        2'd0: if ($urandom % 3 == 0) apply(lvl ^ 3'b010, "R3");
              else apply(lvl | 3'b011, "R2");
        2'd1: if ($urandom % 2 == 0) apply(lvl | 3'b100, "R4");
              else apply(lvl & 3'b110, "R5");
        2'd2: apply(lvl & 3'b011, "R4");
        default: apply(lvl & 3'b101, "R5");
      endcase
    end

    report();
  end

endmodule